// File: doc/BRIEF.md
# Expansion card identity responder

This block sits on an expansion card and answers the host's reads of the card's identity space. Address zero returns a low identity byte. Its fields are a presence bit that reads 0, the live interrupt-status bits, a four-bit ID code and a conformance flag. When the ID code is zero, seven more identity bytes follow: feature flags, product, manufacturer and country. Interrupt-status pointer records can follow those bytes. Each identity byte sits on the lowest data lane of its own 32-bit word slot. The other byte addresses and the upper data lanes read as zero.

The card's interrupt sources are captured once per clock. The captured value drives two things:
- the active-low request lines, modelled as open-drain pull-low controls;
- the status bits the host reads back.

By default these status bits live in the low identity byte. When the relocation option is set, they move to a separate status register, and the pointer records give that register's address and a bit mask for each source. A page register resets to zero, so the identity is visible after reset. While the page is not zero, the identity area reads as zero.

Top module: `card_id_responder`

## Requirements
- R1: The byte at offset 0x00 has bit 1 (presence) = 0, bit 7 (conformance) = 0 and bits 6:3 = the ID code parameter. Bits 0 (normal interrupt status) and 2 (fast interrupt status) carry live status only when status is not relocated, and read 0 otherwise.
- R2: While the normal interrupt source is high and the card provides that source, irqPullN is 0 from the next clock on. Over the same span, status bit 0 (or the relocated IRQ bit) reads 1.
- R3: While the fast interrupt source is high and the card provides that source, fiqPullN is 0 from the next clock on. Over the same span, status bit 2 (or the relocated FIQ bit) reads 1. A card without that source never pulls its line.
- R4: With ID code 0, extended identity bytes 1 to 7 appear at offsets 0x04, 0x08, ... 0x1C:
  - byte 1 = {4'b0, code width[1:0], relocated flag, chunk flag};
  - byte 2 = 0;
  - bytes 3-4 = product code, low byte first;
  - bytes 5-6 = manufacturer code, low byte first;
  - byte 7 = country code.
- R5: Byte addresses with address bits 1:0 not equal to 0 read zero, and read data bits 15:8 are always zero.
- R6: With a non-zero ID code, every identity offset from 0x04 to 0x3C reads zero.
- R7: With status relocated, the register at STAT_OFFSET returns the IRQ status at bit IRQ_BIT and the FIQ status at bit FIQ_BIT, and the low byte's status bits read 0.
- R8: With ID code 0 and either the relocated flag or the chunk flag set, the pointer records are laid out as follows. An absent source gives a zero mask and a zero address.

  | Offset | Content |
  |---|---|
  | 0x20 | FIQ mask |
  | 0x24, 0x28, 0x2C | FIQ 24-bit address, low byte first |
  | 0x30 | IRQ mask |
  | 0x34, 0x38, 0x3C | IRQ 24-bit address, low byte first |

- R9: The page register reads back at PAGE_OFFSET and resets to 0. A write there loads it from wrData[PAGE_W-1:0]. While it is not zero, the identity area (0x00-0x3F) reads zero.
- R10: Writes to any address other than PAGE_OFFSET change no state that can be read back.
- R11: Read data is registered. It updates on the clock edge that samples rdStrobe, resets to 0, and holds when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Card byte address |
| rdStrobe | input | 1 | Read request, one cycle per read |
| wrStrobe | input | 1 | Write request, one cycle per write |
| wrData | input | DATA_W | Write data |
| irqSrc | input | 1 | Normal interrupt source, active high |
| fiqSrc | input | 1 | Fast interrupt source, active high |
| rdData | output | DATA_W | Registered read data |
| irqPullN | output | 1 | 0 = pull the normal interrupt line low |
| fiqPullN | output | 1 | 0 = pull the fast interrupt line low |

## Verification
The bench drives two builds from one stimulus stream.

The first build uses:
- ID code 0, with the relocated and chunk flags set and a 16-bit code width;
- only the normal interrupt source, at relocated bit 5, with the fast source absent.

This build brings within reach the extended bytes, the pointer records, the zero mask of an absent source, and the relocated status register.

The second build uses:
- ID code 5, not relocated;
- both sources present.

This build shows live merging of both status bits into the low byte, and the zero reads above the low byte for a short identity. Paging, write rejection and the byte stride are checked on both builds at once.

// File: rtl/card_id_pkg.sv
package card_id_pkg;

  typedef enum logic [1:0] {
    RG_NONE   = 2'd0,
    RG_IDENT  = 2'd1,
    RG_STATUS = 2'd2,
    RG_PAGE   = 2'd3
  } regionE;

  typedef struct packed {
    logic   load;
    regionE region;
    logic [3:0] entry;
    logic   pageWrite;
  } ctrlStrobeT;

  localparam int ENTRY_COUNT = 16;
  localparam int ENTRY_BITS  = 4;
  localparam int IDENT_SPAN_BITS = ENTRY_BITS + 2;

endpackage

// File: rtl/card_id_ctrl.sv
module card_id_ctrl
  import card_id_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 13'h0800,
  parameter logic [ADDR_W-1:0] PAGE_OFFSET = 13'h1000,
  parameter bit RELOCATE = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  output ctrlStrobeT        strobes
);

  logic aligned;
  logic inIdent;
  logic isStatus;
  logic isPage;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    inIdent  = aligned && (addr[ADDR_W-1:IDENT_SPAN_BITS] == '0);
    isStatus = RELOCATE && (addr == STAT_OFFSET);
    isPage   = (addr == PAGE_OFFSET);

    strobes.load      = rdStrobe;
    strobes.entry     = addr[IDENT_SPAN_BITS-1:2];
    strobes.pageWrite = wrStrobe && isPage;
    if (inIdent)       strobes.region = RG_IDENT;
    else if (isStatus) strobes.region = RG_STATUS;
    else if (isPage)   strobes.region = RG_PAGE;
    else               strobes.region = RG_NONE;
  end

endmodule

// File: rtl/card_id_datapath.sv
module card_id_datapath
  import card_id_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 4,
  parameter logic [3:0] ID_CODE = 4'h0,
  parameter bit RELOCATE = 1'b0,
  parameter bit CHUNK_DIR = 1'b0,
  parameter logic [1:0] CODE_WIDTH = 2'd0,
  parameter logic [15:0] PRODUCT = 16'h0000,
  parameter logic [15:0] MANUF = 16'h0000,
  parameter logic [7:0] COUNTRY = 8'h00,
  parameter logic [23:0] PTR_BASE = 24'h000000,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 13'h0800,
  parameter int IRQ_BIT = 0,
  parameter int FIQ_BIT = 2,
  parameter bit HAS_IRQ = 1'b1,
  parameter bit HAS_FIQ = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqSrc,
  input  logic              fiqSrc,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPullN,
  output logic              fiqPullN
);

  localparam bit EXTENDED = (ID_CODE == 4'h0);
  localparam bit HAS_PTRS = EXTENDED && (RELOCATE || CHUNK_DIR);
  localparam logic [23:0] STAT_ADDR = RELOCATE ? (PTR_BASE + 24'(STAT_OFFSET)) : PTR_BASE;
  localparam logic [7:0] IRQ_MASK = !HAS_IRQ ? 8'h00 : (RELOCATE ? 8'(1 << IRQ_BIT) : 8'h01);
  localparam logic [7:0] FIQ_MASK = !HAS_FIQ ? 8'h00 : (RELOCATE ? 8'(1 << FIQ_BIT) : 8'h04);
  localparam logic [23:0] IRQ_ADDR = HAS_IRQ ? STAT_ADDR : 24'h0;
  localparam logic [23:0] FIQ_ADDR = HAS_FIQ ? STAT_ADDR : 24'h0;

  logic irqStat;
  logic fiqStat;
  logic [PAGE_W-1:0] page;
  logic [7:0] idTable [ENTRY_COUNT];
  logic [7:0] statusByte;
  logic [DATA_W-1:0] nextData;

  generate
    if (HAS_IRQ) begin : gIrq
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) irqStat <= 1'b0;
        else       irqStat <= irqSrc;
      end
    end else begin : gNoIrq
      assign irqStat = 1'b0;
      wire unusedIrq = irqSrc;
    end

    if (HAS_FIQ) begin : gFiq
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) fiqStat <= 1'b0;
        else       fiqStat <= fiqSrc;
      end
    end else begin : gNoFiq
      assign fiqStat = 1'b0;
      wire unusedFiq = fiqSrc;
    end
  endgenerate

  assign irqPullN = ~irqStat;
  assign fiqPullN = ~fiqStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  page <= '0;
    else if (strobes.pageWrite) page <= wrData[PAGE_W-1:0];
  end

  wire unusedWrBits = ^wrData[DATA_W-1:PAGE_W];

  always_comb begin
    for (int i = 0; i < ENTRY_COUNT; i++) idTable[i] = 8'h00;
    idTable[0] = {1'b0, ID_CODE, (RELOCATE ? 1'b0 : fiqStat), 1'b0, (RELOCATE ? 1'b0 : irqStat)};
    if (EXTENDED) begin
      idTable[1] = {4'b0000, CODE_WIDTH, RELOCATE, CHUNK_DIR};
      idTable[3] = PRODUCT[7:0];
      idTable[4] = PRODUCT[15:8];
      idTable[5] = MANUF[7:0];
      idTable[6] = MANUF[15:8];
      idTable[7] = COUNTRY;
    end
    if (HAS_PTRS) begin
      idTable[8]  = FIQ_MASK;
      idTable[9]  = FIQ_ADDR[7:0];
      idTable[10] = FIQ_ADDR[15:8];
      idTable[11] = FIQ_ADDR[23:16];
      idTable[12] = IRQ_MASK;
      idTable[13] = IRQ_ADDR[7:0];
      idTable[14] = IRQ_ADDR[15:8];
      idTable[15] = IRQ_ADDR[23:16];
    end
  end

  always_comb begin
    statusByte = 8'h00;
    if (HAS_IRQ) statusByte[IRQ_BIT] = irqStat;
    if (HAS_FIQ) statusByte[FIQ_BIT] = fiqStat;
  end

  always_comb begin
    nextData = '0;
    case (strobes.region)
      RG_IDENT:  if (page == '0) nextData[7:0] = idTable[strobes.entry];
      RG_STATUS: nextData[7:0] = statusByte;
      RG_PAGE:   nextData[PAGE_W-1:0] = page;
      default:   nextData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobes.load) rdData <= nextData;
  end

  AST_PRESENCE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.region == RG_IDENT && strobes.entry == 4'd0) |=> (rdData[1] == 1'b0 && rdData[7] == 1'b0)) // R1
    else $error("presence or conformance bit set");

  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rstN)
    irqSrc |=> (irqPullN == !HAS_IRQ)) // R2
    else $error("irq line not following source");

  AST_FIQ_LINE: assert property (@(posedge clk) disable iff (!rstN)
    fiqSrc |=> (fiqPullN == !HAS_FIQ)) // R3
    else $error("fiq line not following source");

  AST_UPPER_LANES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:8] == '0) // R5
    else $error("upper data lanes not zero");

  AST_PAGE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pageWrite |=> $stable(page)) // R10
    else $error("page changed without page write");

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(rdData)) // R11
    else $error("read data changed without read");

endmodule

// File: rtl/card_id_responder.sv
module card_id_responder
  import card_id_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 4,
  parameter logic [3:0] ID_CODE = 4'h0,
  parameter bit RELOCATE = 1'b1,
  parameter bit CHUNK_DIR = 1'b1,
  parameter logic [1:0] CODE_WIDTH = 2'd1,
  parameter logic [15:0] PRODUCT = 16'h1234,
  parameter logic [15:0] MANUF = 16'h0056,
  parameter logic [7:0] COUNTRY = 8'h07,
  parameter logic [23:0] PTR_BASE = 24'h3A0000,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 13'h0800,
  parameter logic [ADDR_W-1:0] PAGE_OFFSET = 13'h1000,
  parameter int IRQ_BIT = 5,
  parameter int FIQ_BIT = 3,
  parameter bit HAS_IRQ = 1'b1,
  parameter bit HAS_FIQ = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqSrc,
  input  logic              fiqSrc,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPullN,
  output logic              fiqPullN
);

  generate
    if (CHUNK_DIR && !RELOCATE) begin : gBadCfg
      $error("chunk directory flag needs the relocated-status flag");
    end
  endgenerate

  ctrlStrobeT strobes;

  card_id_ctrl #(
    .ADDR_W(ADDR_W), .STAT_OFFSET(STAT_OFFSET),
    .PAGE_OFFSET(PAGE_OFFSET), .RELOCATE(RELOCATE)
  ) uCtrl (
    .addr(addr), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .strobes(strobes)
  );

  card_id_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .ID_CODE(ID_CODE),
    .RELOCATE(RELOCATE), .CHUNK_DIR(CHUNK_DIR), .CODE_WIDTH(CODE_WIDTH),
    .PRODUCT(PRODUCT), .MANUF(MANUF), .COUNTRY(COUNTRY), .PTR_BASE(PTR_BASE),
    .STAT_OFFSET(STAT_OFFSET), .IRQ_BIT(IRQ_BIT), .FIQ_BIT(FIQ_BIT),
    .HAS_IRQ(HAS_IRQ), .HAS_FIQ(HAS_FIQ)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .irqSrc(irqSrc), .fiqSrc(fiqSrc), .rdData(rdData),
    .irqPullN(irqPullN), .fiqPullN(fiqPullN)
  );

endmodule

// File: tb/card_id_responder_test.sv
`timescale 1ns/1ps
module card_id_responder_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [12:0] addr = '0;
  logic rdStrobe = 1'b0;
  logic wrStrobe = 1'b0;
  logic [15:0] wrData = '0;
  logic irqSrc = 1'b0;
  logic fiqSrc = 1'b0;
  logic [15:0] rdDataA, rdDataB;
  logic irqPullNA, fiqPullNA, irqPullNB, fiqPullNB;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [12:0] a;
    logic [15:0] expA;
    logic [15:0] expB;
    string tag;
  } expItemT;

  expItemT expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Extended identity, status relocated to bit 5, fast source absent
  card_id_responder uut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .wrData(wrData), .irqSrc(irqSrc), .fiqSrc(fiqSrc), .rdData(rdDataA),
    .irqPullN(irqPullNA), .fiqPullN(fiqPullNA)
  );

  // Short identity (ID code 5), status in the low byte, both sources
  card_id_responder #(
    .ID_CODE(4'h5), .RELOCATE(1'b0), .CHUNK_DIR(1'b0), .CODE_WIDTH(2'd0),
    .HAS_IRQ(1'b1), .HAS_FIQ(1'b1)
  ) uutShort (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .wrData(wrData), .irqSrc(irqSrc), .fiqSrc(fiqSrc), .rdData(rdDataB),
    .irqPullN(irqPullNB), .fiqPullN(fiqPullNB)
  );

  task automatic checkVal(input logic [15:0] actual, input logic [15:0] expected, input string tag);
    vectors++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, actual, expected);
    end
  endtask

  task automatic doRead(input logic [12:0] a, input logic [15:0] eA, input logic [15:0] eB, input string tag);
    expItemT it;
    @(negedge clk);
    addr = a;
    rdStrobe = 1'b1;
    it.a = a; it.expA = eA; it.expB = eB; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a;
    wrData = d;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
    @(negedge clk);
  endtask

  // Monitor: compares each strobed read one step after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      if (rdStrobe === 1'b1) begin
        #1;
        if (expQ.size() == 0) begin
          vectors++; fails++;
          $display("FAIL R11: read result with no expected item");
        end else begin
          expItemT it;
          it = expQ.pop_front();
          checkVal(rdDataA, it.expA, {it.tag, " (extended build)"});
          checkVal(rdDataB, it.expB, {it.tag, " (short build)"});
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    vectors++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state, R2/R3 lines released
    checkVal(rdDataA, 16'h0000, "R11 reset rdData");
    checkVal(rdDataB, 16'h0000, "R11 reset rdData");
    checkVal({15'b0, irqPullNA}, 16'h1, "R2 reset line");
    checkVal({15'b0, fiqPullNB}, 16'h1, "R3 reset line");
    rstN = 1'b1;
    @(negedge clk);

    // R9 page register resets to zero
    doRead(13'h1000, 16'h0000, 16'h0000, "R9 page reset");
    // R1, R4, R6 identity bytes
    doRead(13'h0000, 16'h0000, 16'h0028, "R1 low byte");
    doRead(13'h0004, 16'h0007, 16'h0000, "R4 flags / R6");
    doRead(13'h0008, 16'h0000, 16'h0000, "R4 byte2 / R6");
    doRead(13'h000C, 16'h0034, 16'h0000, "R4 product lo / R6");
    doRead(13'h0010, 16'h0012, 16'h0000, "R4 product hi / R6");
    doRead(13'h0014, 16'h0056, 16'h0000, "R4 manuf lo / R6");
    doRead(13'h0018, 16'h0000, 16'h0000, "R4 manuf hi / R6");
    doRead(13'h001C, 16'h0007, 16'h0000, "R4 country / R6");
    // R5 byte stride
    doRead(13'h0001, 16'h0000, 16'h0000, "R5 offset 1");
    doRead(13'h0002, 16'h0000, 16'h0000, "R5 offset 2");
    doRead(13'h0007, 16'h0000, 16'h0000, "R5 offset 7");
    // R8 pointer records (fast source absent on extended build)
    doRead(13'h0020, 16'h0000, 16'h0000, "R8 fiq mask");
    doRead(13'h0024, 16'h0000, 16'h0000, "R8 fiq addr0");
    doRead(13'h002C, 16'h0000, 16'h0000, "R8 fiq addr2");
    doRead(13'h0030, 16'h0020, 16'h0000, "R8 irq mask");
    doRead(13'h0034, 16'h0000, 16'h0000, "R8 irq addr0");
    doRead(13'h0038, 16'h0008, 16'h0000, "R8 irq addr1");
    doRead(13'h003C, 16'h003A, 16'h0000, "R8 irq addr2");
    // R7 relocated status idle
    doRead(13'h0800, 16'h0000, 16'h0000, "R7 status idle");
    drain();

    // R2 normal interrupt asserts
    @(negedge clk); irqSrc = 1'b1;
    @(negedge clk);
    checkVal({15'b0, irqPullNA}, 16'h0, "R2 line pulled (extended)");
    checkVal({15'b0, irqPullNB}, 16'h0, "R2 line pulled (short)");
    doRead(13'h0000, 16'h0000, 16'h0029, "R2 low byte status / R7 zero");
    doRead(13'h0800, 16'h0020, 16'h0000, "R7 relocated irq bit");
    drain();

    // R3 fast interrupt asserts
    @(negedge clk); fiqSrc = 1'b1;
    @(negedge clk);
    checkVal({15'b0, fiqPullNB}, 16'h0, "R3 line pulled (short)");
    checkVal({15'b0, fiqPullNA}, 16'h1, "R3 absent source released");
    doRead(13'h0000, 16'h0000, 16'h002D, "R3 low byte both bits");
    doRead(13'h0800, 16'h0020, 16'h0000, "R7 absent fiq bit");
    drain();

    // R2 clears
    @(negedge clk); irqSrc = 1'b0;
    @(negedge clk);
    checkVal({15'b0, irqPullNB}, 16'h1, "R2 line released");
    doRead(13'h0000, 16'h0000, 16'h002C, "R2 bit clears");
    doRead(13'h0800, 16'h0000, 16'h0000, "R7 bit clears");
    drain();
    // R3 clears
    @(negedge clk); fiqSrc = 1'b0;
    @(negedge clk);
    checkVal({15'b0, fiqPullNB}, 16'h1, "R3 line released");
    doRead(13'h0000, 16'h0000, 16'h0028, "R3 bit clears");

    // R9 paging hides identity
    doWrite(13'h1000, 16'hFFF3);
    doRead(13'h1000, 16'h0003, 16'h0003, "R9 page readback");
    doRead(13'h0004, 16'h0000, 16'h0000, "R9 identity hidden");
    doRead(13'h0000, 16'h0000, 16'h0000, "R9 low byte hidden");
    // R10 write to identity area ignored
    doWrite(13'h0000, 16'h00FF);
    doWrite(13'h0800, 16'h00FF);
    doRead(13'h1000, 16'h0003, 16'h0003, "R10 page untouched");
    doWrite(13'h1000, 16'h0000);
    doRead(13'h0004, 16'h0007, 16'h0000, "R9 identity back at page 0");
    doWrite(13'h0004, 16'h00AA);
    doRead(13'h0004, 16'h0007, 16'h0000, "R10 identity unchanged");
    doRead(13'h1000, 16'h0000, 16'h0000, "R10 page still 0");
    drain();

    // R11 hold without strobe
    @(negedge clk); addr = 13'h0014;
    repeat (3) @(negedge clk);
    checkVal(rdDataA, 16'h0000, "R11 hold (extended)");
    doRead(13'h000C, 16'h0034, 16'h0000, "R11 fresh read");
    drain();
    @(negedge clk); addr = 13'h0000;
    repeat (2) @(negedge clk);
    checkVal(rdDataA, 16'h0034, "R11 hold after read");

    finishRun();
  end

endmodule